// File: doc/BRIEF.md
# Serial Symbol Capture FIFO

This block assembles I and Q symbols that arrive one bit at a time on a serial line. A frame is split into equal time slots of `SYM_W` bits each, sent most significant bit first. Two programmable slot numbers say which slot carries the I symbol and which carries the Q symbol. The finished symbols go into a small FIFO, and a downstream sample-rate strobe drains that FIFO one entry per strobe.

There are two push rules. In pair mode an entry is written only after both the I and the Q symbol of the current frame are complete, whichever of the two slots comes first. In single mode the I symbol is written on its own as soon as its last bit arrives, with a zero Q field. The FIFO reports its fill level and an empty flag. It also reports almost-empty against a programmable threshold, a one-cycle underflow pulse and a full-level overflow flag.

A channel state machine keeps the channel on-line or off-line. Reaching full forces the channel off-line. While off-line, the reader sees zero symbols and incoming symbols are discarded. After a fixed number of reads in the off-line state, a flushed flag is raised. A fresh rising edge on the on-line control brings the channel back with an empty FIFO.

Top module: `sym_capture_fifo`

## Requirements
- R1: In pair mode (`mode_fm`=0), an entry is written on the clock edge that samples the last bit of whichever of the I and Q slots completes second in the frame. Nothing is written when only one of the two has completed. The entry carries I in `rd_i` and Q in `rd_q`.
- R2: In single mode (`mode_fm`=1), an entry is written on the clock edge that samples the last bit of the I slot, and its Q field is zero.
- R3: Which symbol is received first follows only from `i_slot` and `q_slot`. Both orders produce the same pair.
- R4: `fill` counts the stored entries from 0 to 7, and `empty` is 1 exactly when `fill` is 0. Entries leave in the order they were written.
- R5: A read strobe and a write in the same cycle leave `fill` unchanged. At `fill`=0 the symbol being written is passed straight to `rd_i`/`rd_q`.
- R6: `underflow` pulses for one cycle after a read strobe that comes while on-line with `fill`=0 and no write in that cycle.
- R7: `overflow` is 1 while `fill` is 7. On the next edge the channel goes off-line (`is_online`=0).
- R8: `almost_empty` is 1 while `fill` < `ae_thresh`.
- R9: While off-line, `rd_i` and `rd_q` are zero, and completed symbols are not written (`fill` does not change).
- R10: `flushed` rises after the 24th read strobe counted in the off-line state, and not before.
- R11: A rising edge on `online_in` puts the channel on-line on the next edge, empties the FIFO and clears `flushed`. A low `online_in` takes the channel off-line. After reset the channel is off-line.
- R12: Slot k covers the bits k*`SYM_W` through k*`SYM_W`+`SYM_W`-1 of the frame. `frame_sync`, when it comes with a valid bit, marks bit 0 of the frame. Bits are received MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| online_in | input | 1 | On-line request; rising edge brings the channel on-line |
| mode_fm | input | 1 | 1 = single-symbol (I only) mode, 0 = I/Q pair mode |
| i_slot | input | SLOT_W | Slot number carrying the I symbol |
| q_slot | input | SLOT_W | Slot number carrying the Q symbol |
| frame_sync | input | 1 | Marks the first bit of a frame, valid with ser_valid |
| ser_valid | input | 1 | Serial bit qualifier |
| ser_data | input | 1 | Serial bit |
| ae_thresh | input | AW | Almost-empty threshold |
| rd_stb | input | 1 | Sample-rate read strobe |
| rd_i | output | SYM_W | I symbol presented to the reader |
| rd_q | output | SYM_W | Q symbol presented to the reader |
| fill | output | AW | Stored entry count |
| empty | output | 1 | Fill is zero |
| almost_empty | output | 1 | Fill below threshold |
| overflow | output | 1 | Fill at its maximum |
| underflow | output | 1 | One-cycle pulse after a read of an empty FIFO |
| flushed | output | 1 | Enough off-line reads have passed |
| is_online | output | 1 | Channel state |

## Verification
The two functions that can coincide are the push from the serial side and the read strobe from the reader. The bench raises `rd_stb` on exactly the cycle that carries the last bit of the I slot. It does this once with one entry stored and once with an empty FIFO. It then judges that `fill` keeps its value in both cases, that the stored head is read in the first case, and that the symbol being written is passed straight through in the second case with no underflow pulse. A bare read on the empty FIFO is then used to confirm that the underflow pulse appears only when no write is present.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  // Next fill level given a write and a read in the same cycle.
  function automatic logic [7:0] fill_step(input logic [7:0] c, input logic inc, input logic dec);
    logic [7:0] r;
    r = c;
    if (inc && !dec) r = c + 8'd1;
    else if (dec && !inc) r = c - 8'd1;
    return r;
  endfunction

  // Almost-empty comparison.
  function automatic logic below_thr(input logic [7:0] c, input logic [7:0] thr);
    return c < thr;
  endfunction
endpackage

// File: rtl/ssf_slot_capture.sv
module ssf_slot_capture #(
  parameter int SYM_W = 8,
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W = $clog2(SYM_W),
  localparam int POS_W = BIT_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_valid,
  input  logic              ser_data,
  input  logic              frame_sync,
  input  logic              mode_fm,
  input  logic [SLOT_W-1:0] i_slot,
  input  logic [SLOT_W-1:0] q_slot,
  output logic              push,
  output logic [SYM_W-1:0]  push_i,
  output logic [SYM_W-1:0]  push_q
);
  logic [POS_W-1:0]  pos, cur_pos;
  logic [SYM_W-1:0]  sh, word, i_hold, q_hold;
  logic              got_i, got_q, had_i, had_q;
  logic              last_bit, i_done, q_done;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    cur_pos  = frame_sync ? '0 : pos;
    word     = {sh[SYM_W-2:0], ser_data};
    slot     = cur_pos[POS_W-1:BIT_W];
    last_bit = ser_valid && (cur_pos[BIT_W-1:0] == BIT_W'(SYM_W-1));
    i_done   = last_bit && (slot == i_slot);
    q_done   = last_bit && (slot == q_slot);
    had_i    = got_i && !frame_sync;
    had_q    = got_q && !frame_sync;
    if (mode_fm) push = i_done;
    else         push = (i_done || q_done) && (i_done || had_i) && (q_done || had_q);
    push_i   = i_done ? word : i_hold;
    push_q   = mode_fm ? '0 : (q_done ? word : q_hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      sh     <= '0;
      got_i  <= 1'b0;
      got_q  <= 1'b0;
      i_hold <= '0;
      q_hold <= '0;
    end else if (ser_valid) begin
      pos   <= cur_pos + POS_W'(1);
      sh    <= word;
      got_i <= i_done || had_i;
      got_q <= q_done || had_q;
      if (i_done) i_hold <= word;
      if (q_done) q_hold <= word;
    end
  end
endmodule

// File: rtl/ssf_fifo.sv
module ssf_fifo
  import ssf_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int AW = 3,
  localparam int DEPTH = 2 ** AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr,
  input  logic [SYM_W-1:0] wr_i,
  input  logic [SYM_W-1:0] wr_q,
  input  logic             rd,
  output logic [AW-1:0]    count,
  output logic [SYM_W-1:0] head_i,
  output logic [SYM_W-1:0] head_q
);
  logic [2*SYM_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr, rd_ptr;

  assign {head_i, head_q} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr && !clear) mem[wr_ptr] <= {wr_i, wr_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr) wr_ptr <= wr_ptr + AW'(1);
      if (rd) rd_ptr <= rd_ptr + AW'(1);
      count <= AW'(fill_step(8'(count), wr, rd));
    end
  end
endmodule

// File: rtl/ssf_chan_ctrl.sv
module ssf_chan_ctrl #(
  parameter int FLUSH_N = 24,
  localparam int FC_W = $clog2(FLUSH_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic online_in,
  input  logic full,
  input  logic rd_stb,
  output logic on_rise,
  output logic online,
  output logic flushed
);
  logic            online_d;
  logic [FC_W-1:0] fcnt;

  assign on_rise = online_in && !online_d;
  assign flushed = (fcnt == FC_W'(FLUSH_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      online_d <= 1'b0;
      online   <= 1'b0;
      fcnt     <= '0;
    end else begin
      online_d <= online_in;
      if (on_rise)                 online <= 1'b1;
      else if (!online_in || full) online <= 1'b0;
      if (on_rise)                           fcnt <= '0;
      else if (!online && rd_stb && !flushed) fcnt <= fcnt + FC_W'(1);
    end
  end
endmodule

// File: rtl/sym_capture_fifo.sv
module sym_capture_fifo
  import ssf_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int SLOTS = 4,
  parameter int AW = 3,
  parameter int FLUSH_N = 24,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              online_in,
  input  logic              mode_fm,
  input  logic [SLOT_W-1:0] i_slot,
  input  logic [SLOT_W-1:0] q_slot,
  input  logic              frame_sync,
  input  logic              ser_valid,
  input  logic              ser_data,
  input  logic [AW-1:0]     ae_thresh,
  input  logic              rd_stb,
  output logic [SYM_W-1:0]  rd_i,
  output logic [SYM_W-1:0]  rd_q,
  output logic [AW-1:0]     fill,
  output logic              empty,
  output logic              almost_empty,
  output logic              overflow,
  output logic              underflow,
  output logic              flushed,
  output logic              is_online
);
  localparam logic [AW-1:0] FULL = AW'(2 ** AW - 1);

  logic             push, wr_evt, pop_evt, on_rise, full;
  logic [SYM_W-1:0] push_i, push_q, head_i, head_q;

  ssf_slot_capture #(.SYM_W(SYM_W), .SLOTS(SLOTS)) u_cap (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_data(ser_data),
    .frame_sync(frame_sync), .mode_fm(mode_fm), .i_slot(i_slot), .q_slot(q_slot),
    .push(push), .push_i(push_i), .push_q(push_q)
  );

  assign full    = (fill == FULL);
  assign wr_evt  = push && is_online && (!full || rd_stb);
  assign pop_evt = rd_stb && is_online && ((fill != '0) || wr_evt);

  ssf_fifo #(.SYM_W(SYM_W), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(on_rise), .wr(wr_evt), .wr_i(push_i),
    .wr_q(push_q), .rd(pop_evt), .count(fill), .head_i(head_i), .head_q(head_q)
  );

  ssf_chan_ctrl #(.FLUSH_N(FLUSH_N)) u_ctl (
    .clk(clk), .rst_n(rst_n), .online_in(online_in), .full(full),
    .rd_stb(rd_stb), .on_rise(on_rise), .online(is_online), .flushed(flushed)
  );

  always_comb begin
    rd_i = '0;
    rd_q = '0;
    if (is_online) begin
      if (fill != '0) begin
        rd_i = head_i;
        rd_q = head_q;
      end else if (wr_evt) begin
        rd_i = push_i;
        rd_q = push_q;
      end
    end
  end

  assign empty        = (fill == '0);
  assign overflow     = full;
  assign almost_empty = below_thr(8'(fill), 8'(ae_thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow <= 1'b0;
    else        underflow <= is_online && rd_stb && (fill == '0) && !wr_evt;
  end
endmodule

// File: rtl/sym_capture_fifo_chk.sv
module sym_capture_fifo_chk #(
  parameter int SYM_W = 8,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on_rise,
  input logic             wr_evt,
  input logic             pop_evt,
  input logic             mode_fm,
  input logic             rd_stb,
  input logic [SYM_W-1:0] push_q,
  input logic [AW-1:0]    fill,
  input logic             is_online,
  input logic [SYM_W-1:0] rd_i,
  input logic [SYM_W-1:0] rd_q,
  input logic             underflow,
  input logic             flushed
);
  localparam logic [AW-1:0] FULL = AW'(2 ** AW - 1);

  a_r5_rw_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && pop_evt && !on_rise) |=> (fill == $past(fill)));

  a_r7_full_forces_offline: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL && !on_rise) |=> !is_online);

  a_r9_offline_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    !is_online |-> (rd_i == '0 && rd_q == '0));

  a_r10_flushed_only_offline: assert property (@(posedge clk) disable iff (!rst_n)
    flushed |-> !is_online);

  a_r6_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(is_online && rd_stb && fill == '0 && !wr_evt));

  a_r11_rise_empties: assert property (@(posedge clk) disable iff (!rst_n)
    on_rise |=> (fill == '0 && is_online && !flushed));

  a_r2_single_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && mode_fm) |-> (push_q == '0));
endmodule

bind sym_capture_fifo sym_capture_fifo_chk #(.SYM_W(SYM_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .on_rise(on_rise), .wr_evt(wr_evt), .pop_evt(pop_evt),
  .mode_fm(mode_fm), .rd_stb(rd_stb), .push_q(push_q), .fill(fill),
  .is_online(is_online), .rd_i(rd_i), .rd_q(rd_q), .underflow(underflow),
  .flushed(flushed)
);

// File: tb/sim_sym_capture_fifo.sv
`timescale 1ns/100ps
module sim_sym_capture_fifo;
  localparam int SYM_W = 8;
  localparam int SLOTS = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic online_in = 1'b0, mode_fm = 1'b1, frame_sync = 1'b0;
  logic ser_valid = 1'b0, ser_data = 1'b0, rd_stb = 1'b0;
  logic [1:0] i_slot = 2'd0, q_slot = 2'd1;
  logic [AW-1:0] ae_thresh = 3'd1;
  logic [SYM_W-1:0] rd_i, rd_q, cap_i, cap_q;
  logic [AW-1:0] fill;
  logic empty, almost_empty, overflow, underflow, flushed, is_online;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sym_capture_fifo #(.SYM_W(SYM_W), .SLOTS(SLOTS), .AW(AW), .FLUSH_N(24)) u0 (
    .clk(clk), .rst_n(rst_n), .online_in(online_in), .mode_fm(mode_fm),
    .i_slot(i_slot), .q_slot(q_slot), .frame_sync(frame_sync), .ser_valid(ser_valid),
    .ser_data(ser_data), .ae_thresh(ae_thresh), .rd_stb(rd_stb), .rd_i(rd_i),
    .rd_q(rd_q), .fill(fill), .empty(empty), .almost_empty(almost_empty),
    .overflow(overflow), .underflow(underflow), .flushed(flushed), .is_online(is_online)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive frame positions first..last; optional read strobe on the last one.
  task automatic send_bits(input logic [7:0] iv, input logic [7:0] qv,
                           input int first, input int last, input bit rd_last);
    for (int p = first; p <= last; p++) begin
      int s, b;
      s = p / SYM_W;
      b = p % SYM_W;
      @(negedge clk);
      ser_valid  = 1'b1;
      frame_sync = (p == 0);
      ser_data   = (s == int'(i_slot)) ? iv[SYM_W-1-b] :
                   (s == int'(q_slot)) ? qv[SYM_W-1-b] : 1'b0;
      rd_stb     = rd_last && (p == last);
      #0.5;
      if (rd_stb) begin cap_i = rd_i; cap_q = rd_q; end
      @(posedge clk);
    end
    @(negedge clk);
    ser_valid = 1'b0; frame_sync = 1'b0; rd_stb = 1'b0;
    #0.5;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_stb = 1'b1;
    #0.5;
    cap_i = rd_i; cap_q = rd_q;
    @(posedge clk);
    #0.5 rd_stb = 1'b0;
    @(negedge clk);
    #0.5;
  endtask

  task automatic t_reset();
    chk(fill == 0, "R4", "fill after reset", fill, 0);
    chk(empty == 1, "R4", "empty after reset", empty, 1);
    chk(is_online == 0, "R11", "offline after reset", is_online, 0);
    chk(flushed == 0 && overflow == 0, "R10", "flags after reset", {flushed, overflow}, 0);
  endtask

  task automatic t_offline_ignored();
    mode_fm = 1; i_slot = 0; q_slot = 1;
    send_bits(8'h3D, 8'h00, 0, 31, 0);
    chk(fill == 0, "R9", "no write while offline", fill, 0);
    chk(rd_i == 0, "R9", "zero output offline", rd_i, 0);
  endtask

  task automatic t_online();
    @(negedge clk); online_in = 1;
    @(negedge clk); #0.5;
    chk(is_online == 1, "R11", "online after rise", is_online, 1);
  endtask

  task automatic t_single();
    mode_fm = 1; i_slot = 1; q_slot = 2;
    send_bits(8'hA5, 8'hFF, 0, 14, 0);
    chk(fill == 0, "R12", "no write before I slot last bit", fill, 0);
    send_bits(8'hA5, 8'hFF, 15, 15, 0);
    chk(fill == 1, "R2", "write at I last bit", fill, 1);
    send_bits(8'hA5, 8'hFF, 16, 31, 0);
    do_read();
    chk(cap_i == 8'hA5, "R2", "single I value", cap_i, 8'hA5);
    chk(cap_q == 0, "R2", "single Q zero", cap_q, 0);
    chk(empty == 1, "R4", "empty after drain", empty, 1);
  endtask

  task automatic t_pair_q_first();
    mode_fm = 0; q_slot = 0; i_slot = 3;
    send_bits(8'h3C, 8'hC3, 0, 30, 0);
    chk(fill == 0, "R1", "no write with only Q done", fill, 0);
    send_bits(8'h3C, 8'hC3, 31, 31, 0);
    chk(fill == 1, "R1", "write after both", fill, 1);
    do_read();
    chk(cap_i == 8'h3C && cap_q == 8'hC3, "R3", "pair Q-first", {cap_i, cap_q}, 16'h3CC3);
  endtask

  task automatic t_pair_i_first();
    mode_fm = 0; i_slot = 1; q_slot = 2;
    send_bits(8'h5A, 8'h96, 0, 22, 0);
    chk(fill == 0, "R1", "no write with only I done", fill, 0);
    send_bits(8'h5A, 8'h96, 23, 31, 0);
    chk(fill == 1, "R1", "write after Q", fill, 1);
    do_read();
    chk(cap_i == 8'h5A && cap_q == 8'h96, "R3", "pair I-first", {cap_i, cap_q}, 16'h5A96);
  endtask

  task automatic t_almost_empty();
    mode_fm = 1; i_slot = 0; q_slot = 1;
    send_bits(8'h11, 0, 0, 31, 0);
    send_bits(8'h22, 0, 0, 31, 0);
    ae_thresh = 3; #0.5;
    chk(almost_empty == 1, "R8", "fill 2 < 3", almost_empty, 1);
    ae_thresh = 2; #0.5;
    chk(almost_empty == 0, "R8", "fill 2 not < 2", almost_empty, 0);
    do_read();
    chk(cap_i == 8'h11, "R4", "first in first out", cap_i, 8'h11);
    do_read();
    chk(cap_i == 8'h22, "R4", "second out", cap_i, 8'h22);
    chk(almost_empty == 1, "R8", "fill 0 < 2", almost_empty, 1);
  endtask

  task automatic t_same_cycle();
    mode_fm = 1; i_slot = 0; q_slot = 1;
    send_bits(8'h77, 0, 0, 31, 0);
    send_bits(8'h88, 0, 0, 7, 1);
    chk(fill == 1, "R5", "read+write holds fill", fill, 1);
    chk(cap_i == 8'h77, "R5", "head read during write", cap_i, 8'h77);
    send_bits(8'h88, 0, 8, 31, 0);
    do_read();
    chk(cap_i == 8'h88 && fill == 0, "R5", "second entry", cap_i, 8'h88);
    send_bits(8'h99, 0, 0, 7, 1);
    chk(fill == 0, "R5", "bypass keeps fill 0", fill, 0);
    chk(cap_i == 8'h99, "R5", "bypass data", cap_i, 8'h99);
    chk(underflow == 0, "R6", "no underflow on bypass", underflow, 0);
    send_bits(8'h99, 0, 8, 31, 0);
  endtask

  task automatic t_underflow();
    do_read();
    chk(underflow == 1, "R6", "pulse after empty read", underflow, 1);
    @(negedge clk); #0.5;
    chk(underflow == 0, "R6", "pulse lasts one cycle", underflow, 0);
  endtask

  task automatic t_overflow();
    mode_fm = 1; i_slot = 0;
    for (int k = 0; k < 7; k++) send_bits(8'(8'h40 + k), 0, 0, 31, 0);
    chk(fill == 7, "R4", "fill reaches 7", fill, 7);
    chk(overflow == 1, "R7", "overflow at 7", overflow, 1);
    chk(is_online == 0, "R7", "forced offline", is_online, 0);
    chk(rd_i == 0 && rd_q == 0, "R9", "zero output offline", rd_i, 0);
    send_bits(8'hEE, 0, 0, 31, 0);
    chk(fill == 7, "R9", "offline write ignored", fill, 7);
  endtask

  task automatic t_flush();
    for (int k = 0; k < 23; k++) do_read();
    chk(flushed == 0, "R10", "not flushed after 23", flushed, 0);
    chk(cap_i == 0, "R9", "offline read zero", cap_i, 0);
    do_read();
    chk(flushed == 1, "R10", "flushed after 24", flushed, 1);
  endtask

  task automatic t_reonline();
    @(negedge clk); online_in = 0;
    @(negedge clk); online_in = 1;
    @(negedge clk); #0.5;
    chk(is_online == 1, "R11", "back online", is_online, 1);
    chk(fill == 0 && flushed == 0, "R11", "emptied and cleared", {fill, flushed}, 0);
    @(negedge clk); online_in = 0;
    @(negedge clk); #0.5;
    chk(is_online == 0, "R11", "low request goes offline", is_online, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #0.5;
    t_reset();
    t_offline_ignored();
    t_online();
    t_single();
    t_pair_q_first();
    t_pair_i_first();
    t_almost_empty();
    t_same_cycle();
    t_underflow();
    t_overflow();
    t_flush();
    t_reonline();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule